// File: doc/BRIEF.md
# Test-and-Set Lock Bank

This block is a bank of hardware mutual-exclusion locks that several bus masters share. Each lock occupies one word address and holds a single state bit, where 1 means held and 0 means free. A read of a lock is destructive and atomic. It returns the lock's state in bit 0 of the read data and leaves the lock held, in the same access. A processor therefore acquires a lock by reading it and finding 0. It releases the lock by writing a word whose bit 0 is 0.

Every master has its own read strobe, write strobe, address and write data. A round-robin arbiter grants one master per cycle and raises that master's ready. The other masters keep their strobes asserted until they are granted. The read result returns one cycle after the grant, together with a per-master valid flag.

Reset starts a bulk clear that walks through every lock, one lock per cycle. The block holds `busy` high until the clear is done and grants nothing while it is busy. The set size is a parameter. A full set of 16384 locks is obtained by setting `N_LOCKS` to 16384.

Top module: `lock_bank`

## Requirements
- R1: After reset is released, `busy` stays high for exactly `N_LOCKS` clock cycles. No `m_ready` is raised while `busy` is high. When `busy` falls, every lock reads 0. Asserting reset again in the middle of operation repeats this clear.
- R2: A granted read returns the addressed lock's previous state in bit 0 of `m_rdata` (1 = held, 0 = free). It sets that lock to 1 at the same clock edge.
- R3: Bits DW-1 to 1 of `m_rdata` are 0 whenever any `m_rvalid` bit is high.
- R4: A granted write stores bit 0 of that master's write data into the lock, so 0 releases it and 1 sets it. Bits DW-1 to 1 of the write data have no effect. A write produces no `m_rvalid`.
- R5: For a read granted in cycle t, the granted master's `m_rvalid` bit is high in cycle t+1 and no other `m_rvalid` bit is high.
- R6: At most one `m_ready` bit is high in any cycle. It is raised only for a master whose read or write strobe is high. Masters that are not granted see `m_ready` low and keep their request.
- R7: Arbitration is round-robin. After reset master 0 has the highest priority. After a grant to master i, the search for the next grant starts at master i+1 and wraps around.
- R8: When two reads of the same free lock are granted in back-to-back cycles, the first reader receives 0 and the second receives 1.
- R9: A master that raises both strobes in the same cycle performs a read. Its write data is ignored.
- R10: An access to one lock leaves the state of every other lock unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the bulk clear |
| m_rd | input | N_MASTERS | Per-master read (acquire) strobe, held until ready |
| m_wr | input | N_MASTERS | Per-master write strobe, held until ready |
| m_addr | input | N_MASTERS*AW | Per-master lock address, master i at bits [i*AW +: AW] |
| m_wdata | input | N_MASTERS*DW | Per-master write data, master i at bits [i*DW +: DW]; only bit 0 is used |
| m_ready | output | N_MASTERS | One-hot grant; the access is taken at the next clock edge |
| m_rvalid | output | N_MASTERS | Read result valid for that master, one cycle after the grant |
| m_rdata | output | DW | Shared read data; bit 0 is the old lock state |
| busy | output | 1 | High while the bulk clear is in progress |

## Verification
A wrong stored lock bit appears at the ports on the next read of that address, as a wrong bit 0. The bench checks every address after every phase of the sweep, so a corrupted neighbour or a missed update is found within one pass over the set. A fault in the arbiter pointer appears in the very next cycle of contention, as a grant to the wrong master. A fault in the read-data path appears one cycle after the grant, as a missing valid flag or a wrong bit. A clear sequencer that is off by one shows up as a busy window of the wrong length.

// File: rtl/lock_bank_pkg.sv
// Package: lock_bank_pkg
// Shared types and helpers for the lock bank.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package lock_bank_pkg;

    // Kind of access that the granted master performs this cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Width of an index that addresses n items, at least one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lock_rr_arb.sv
// Module: lock_rr_arb
// Round-robin arbiter. It grants at most one requester per cycle while en
// is high. The search starts one place after the last granted index and
// wraps around. After reset the last index is N_REQ-1, so index 0 has the
// highest priority first.
// Assumes: requesters hold their request until they see their grant.
module lock_rr_arb #(
    parameter int N_REQ = 4,
    localparam int IW = lock_bank_pkg::idx_width(N_REQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] grant,
    output logic [IW-1:0]    gidx
);

    logic [IW-1:0] last_q;
    logic          found;

    // Pick the first requester after last_q, in circular order.
    always_comb begin
        int idx;
        grant = '0;
        gidx  = '0;
        found = 1'b0;
        for (int off = 1; off <= N_REQ; off++) begin
            idx = (int'(last_q) + off) % N_REQ;
            if (en && req[idx] && !found) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                gidx       = IW'(idx);
            end
        end
    end

    // Remember the most recent winner so that priority rotates past it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IW'(N_REQ - 1);
        end else if (found) begin
            last_q <= gidx;
        end
    end

endmodule

// File: rtl/lock_req_mux.sv
// Module: lock_req_mux
// Selects the address, access kind and write bit of the granted master.
// A master that raises both strobes is treated as a reader.
// Assumes: gidx is valid only when any_grant is high.
module lock_req_mux #(
    parameter int N_MASTERS = 4,
    parameter int AW        = 11,
    localparam int IW = lock_bank_pkg::idx_width(N_MASTERS)
) (
    input  logic [N_MASTERS-1:0]    m_rd,
    input  logic [N_MASTERS-1:0]    m_wr,
    input  logic [N_MASTERS*AW-1:0] m_addr,
    input  logic [N_MASTERS-1:0]    m_wbit,
    input  logic                    any_grant,
    input  logic [IW-1:0]           gidx,
    output lock_bank_pkg::acc_kind_e sel_kind,
    output logic [AW-1:0]           sel_addr,
    output logic                    sel_wbit
);

    logic [AW-1:0] addr_arr [N_MASTERS];

    // Slice the flat address bus into one entry per master.
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_slice
        assign addr_arr[g] = m_addr[g*AW +: AW];
    end

    // Route the winner's fields; the read strobe takes precedence.
    always_comb begin
        sel_addr = addr_arr[gidx];
        sel_wbit = m_wbit[gidx];
        if (!any_grant) begin
            sel_kind = lock_bank_pkg::ACC_IDLE;
        end else if (m_rd[gidx]) begin
            sel_kind = lock_bank_pkg::ACC_READ;
        end else if (m_wr[gidx]) begin
            sel_kind = lock_bank_pkg::ACC_WRITE;
        end else begin
            sel_kind = lock_bank_pkg::ACC_IDLE;
        end
    end

endmodule

// File: rtl/lock_store.sv
// Module: lock_store
// Storage of N_LOCKS one-bit locks, plus the sequencer that clears them
// after reset. The old bit is read combinationally. A read access writes 1
// and a write access writes wbit, both at the clock edge that ends the
// access. While busy, the sequencer zeroes one lock per cycle.
// Assumes: N_LOCKS is a power of two, and no access arrives while busy.
module lock_store #(
    parameter int N_LOCKS = 2048,
    localparam int AW = lock_bank_pkg::idx_width(N_LOCKS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  lock_bank_pkg::acc_kind_e kind,
    input  logic [AW-1:0]            addr,
    input  logic                     wbit,
    output logic                     old_bit,
    output logic                     busy
);

    logic          mem [N_LOCKS];
    logic [AW-1:0] clr_idx_q;
    logic          busy_q;

    assign busy    = busy_q;
    assign old_bit = mem[addr];

    // Step the clear pointer across the whole set after each reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b1;
            clr_idx_q <= '0;
        end else if (busy_q) begin
            if (clr_idx_q == AW'(N_LOCKS - 1)) begin
                busy_q <= 1'b0;
            end else begin
                clr_idx_q <= clr_idx_q + 1'b1;
            end
        end
    end

    // Single write port: the clear has priority, then the granted access.
    always_ff @(posedge clk) begin
        if (busy_q) begin
            mem[clr_idx_q] <= 1'b0;
        end else if (kind == lock_bank_pkg::ACC_READ) begin
            mem[addr] <= 1'b1;
        end else if (kind == lock_bank_pkg::ACC_WRITE) begin
            mem[addr] <= wbit;
        end
    end

endmodule

// File: rtl/lock_bank.sv
// Module: lock_bank
// Top of the test-and-set lock bank. N_MASTERS request ports compete through
// a round-robin arbiter. The winner's access executes atomically in one
// cycle. A read result is registered and returned one cycle after the grant.
// Assumes: masters hold their strobes and fields stable until m_ready, and
// N_LOCKS is a power of two.
module lock_bank #(
    parameter int N_MASTERS = 4,
    parameter int N_LOCKS   = 2048,
    parameter int DW        = 32,
    localparam int AW = lock_bank_pkg::idx_width(N_LOCKS),
    localparam int IW = lock_bank_pkg::idx_width(N_MASTERS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_MASTERS-1:0]    m_rd,
    input  logic [N_MASTERS-1:0]    m_wr,
    input  logic [N_MASTERS*AW-1:0] m_addr,
    input  logic [N_MASTERS*DW-1:0] m_wdata,
    output logic [N_MASTERS-1:0]    m_ready,
    output logic [N_MASTERS-1:0]    m_rvalid,
    output logic [DW-1:0]           m_rdata,
    output logic                    busy
);

    logic [N_MASTERS-1:0]       wbit;
    logic [N_MASTERS*(DW-1)-1:0] wdata_hi;
    logic                       unused_wdata_hi;
    logic [N_MASTERS-1:0]       grant;
    logic [IW-1:0]              gidx;
    lock_bank_pkg::acc_kind_e   sel_kind;
    logic [AW-1:0]              sel_addr;
    logic                       sel_wbit;
    logic                       old_bit;
    logic                       store_busy;
    logic [N_MASTERS-1:0]       rvalid_q;
    logic                       rbit_q;

    // Split each write word into the state bit and the ignored upper bits.
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_wsplit
        assign wbit[g]                       = m_wdata[g*DW];
        assign wdata_hi[g*(DW-1) +: (DW-1)]  = m_wdata[g*DW+1 +: (DW-1)];
    end
    assign unused_wdata_hi = ^wdata_hi;

    lock_rr_arb #(
        .N_REQ (N_MASTERS)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (!store_busy),
        .req   (m_rd | m_wr),
        .grant (grant),
        .gidx  (gidx)
    );

    lock_req_mux #(
        .N_MASTERS (N_MASTERS),
        .AW        (AW)
    ) u_mux (
        .m_rd      (m_rd),
        .m_wr      (m_wr),
        .m_addr    (m_addr),
        .m_wbit    (wbit),
        .any_grant (|grant),
        .gidx      (gidx),
        .sel_kind  (sel_kind),
        .sel_addr  (sel_addr),
        .sel_wbit  (sel_wbit)
    );

    lock_store #(
        .N_LOCKS (N_LOCKS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (sel_kind),
        .addr    (sel_addr),
        .wbit    (sel_wbit),
        .old_bit (old_bit),
        .busy    (store_busy)
    );

    // Register the read response: valid flag per master and the old bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= '0;
            rbit_q   <= 1'b0;
        end else begin
            rvalid_q <= (sel_kind == lock_bank_pkg::ACC_READ) ? grant : '0;
            if (sel_kind == lock_bank_pkg::ACC_READ) begin
                rbit_q <= old_bit;
            end
        end
    end

    assign m_ready  = grant;
    assign m_rvalid = rvalid_q;
    assign m_rdata  = {{(DW-1){1'b0}}, rbit_q};
    assign busy     = store_busy;

endmodule

// File: rtl/lock_bank_chk.sv
// Module: lock_bank_chk
// Port-level protocol checks for lock_bank, attached with bind below.
// Assumes: the same parameter values as the bound instance.
module lock_bank_chk #(
    parameter int N_MASTERS = 4,
    parameter int DW        = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] m_rd,
    input logic [N_MASTERS-1:0] m_wr,
    input logic [N_MASTERS-1:0] m_ready,
    input logic [N_MASTERS-1:0] m_rvalid,
    input logic [DW-1:0]        m_rdata,
    input logic                 busy
);

    // R1: no grant during the bulk clear.
    p_no_ready_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (m_ready == '0));

    // R1: the clear never restarts without a reset.
    p_busy_no_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy));

    // R6: at most one grant per cycle.
    p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_ready));

    // R6: a grant only goes to a master that is requesting.
    p_grant_to_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ready & ~(m_rd | m_wr)) == '0);

    // R5: a granted read yields that master's valid flag one cycle later.
    p_rvalid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(m_ready & m_rd)) |=> (m_rvalid == $past(m_ready & m_rd)));

    // R4: no valid flag without a read grant in the previous cycle.
    p_no_spurious_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(m_ready & m_rd)) |=> (m_rvalid == '0));

    // R3: upper read data bits stay zero while a result is presented.
    p_rdata_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_rvalid) |-> (m_rdata[DW-1:1] == '0));

endmodule

bind lock_bank lock_bank_chk #(
    .N_MASTERS (N_MASTERS),
    .DW        (DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_rd     (m_rd),
    .m_wr     (m_wr),
    .m_ready  (m_ready),
    .m_rvalid (m_rvalid),
    .m_rdata  (m_rdata),
    .busy     (busy)
);

// File: tb/tb_lock_bank.sv
// Bench for lock_bank: 3 masters, 16 locks, sweeps over every address.
module tb_lock_bank;

    localparam int NM = 3;
    localparam int NL = 16;
    localparam int DW = 32;
    localparam int AW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NM-1:0]     m_rd = '0;
    logic [NM-1:0]     m_wr = '0;
    logic [NM*AW-1:0]  m_addr = '0;
    logic [NM*DW-1:0]  m_wdata = '0;
    logic [NM-1:0]     m_ready;
    logic [NM-1:0]     m_rvalid;
    logic [DW-1:0]     m_rdata;
    logic              busy;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  model [NL];
    int  last_g   = NM - 1;

    // Per-master stimulus for the contention phases.
    bit          c_rd [NM];
    bit          c_wr [NM];
    int          c_ad [NM];
    logic [31:0] c_wd [NM];

    lock_bank #(.N_MASTERS(NM), .N_LOCKS(NL), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .m_rd(m_rd), .m_wr(m_wr), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rvalid(m_rvalid),
        .m_rdata(m_rdata), .busy(busy)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    function automatic void model_apply(input int m);
        if (c_rd[m]) model[c_ad[m]] = 1'b1;
        else if (c_wr[m]) model[c_ad[m]] = c_wd[m][0];
    endfunction

    // Drive all masters in mask at once, then follow grants to completion.
    task automatic contend(input bit [NM-1:0] mask, input string req);
        bit [NM-1:0] pend = mask;
        int guard = 0;
        @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            if (mask[m]) begin
                m_rd[m] = c_rd[m];
                m_wr[m] = c_wr[m];
                m_addr[m*AW +: AW] = AW'(c_ad[m]);
                m_wdata[m*DW +: DW] = c_wd[m];
            end
        end
        while (pend != '0 && guard < 100) begin
            int e = -1;
            bit expb;
            guard++;
            #1;
            for (int off = 1; off <= NM; off++) begin
                int k = (last_g + off) % NM;
                if (pend[k] && e < 0) e = k;
            end
            chk(m_ready == NM'(1 << e), req, "grant order", m_ready, 1 << e);
            expb = model[c_ad[e]];
            @(negedge clk);
            if (c_rd[e]) begin
                chk(m_rvalid == NM'(1 << e), "R5", "rvalid", m_rvalid, 1 << e);
                chk(m_rdata == 32'(expb), "R2", "read bit", m_rdata, expb);
            end else begin
                chk(m_rvalid == '0, "R4", "no rvalid on write", m_rvalid, 0);
            end
            model_apply(e);
            m_rd[e] = 1'b0;
            m_wr[e] = 1'b0;
            pend[e] = 1'b0;
            last_g = e;
        end
    endtask

    task automatic acc(input int m, input bit r, input bit w, input int a,
                       input logic [31:0] wd, input string req);
        for (int k = 0; k < NM; k++) begin
            c_rd[k] = 1'b0; c_wr[k] = 1'b0;
        end
        c_rd[m] = r; c_wr[m] = w; c_ad[m] = a; c_wd[m] = wd;
        contend(NM'(1 << m), req);
    endtask

    task automatic do_reset();
        int cnt = 0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // Master 0 requests during the clear; it must wait.
        m_rd[0] = 1'b1;
        m_addr[0 +: AW] = AW'(5);
        rst_n = 1'b1;
        #1;
        while (busy && cnt < 1000) begin
            cnt++;
            chk(m_ready == '0, "R1", "ready while busy", m_ready, 0);
            @(negedge clk);
            #1;
        end
        chk(cnt == NL, "R1", "busy cycles", cnt, NL);
        chk(m_ready == 3'b001, "R7", "first grant after reset", m_ready, 1);
        @(negedge clk);
        chk(m_rvalid == 3'b001 && m_rdata == 32'd0, "R1", "cleared lock", m_rdata, 0);
        m_rd = '0;
        for (int a = 0; a < NL; a++) model[a] = 1'b0;
        model[5] = 1'b1;
        last_g = 0;
    endtask

    initial begin
        do_reset();

        // R2 R10: acquire every lock once, rotating masters.
        for (int a = 0; a < NL; a++) acc(a % NM, 1, 0, a, '0, "R2");
        // R2: every lock now reads held.
        for (int a = 0; a < NL; a++) acc((a + 1) % NM, 1, 0, a, '0, "R2");

        // R4 R10: release even locks with garbage in the upper bits.
        for (int a = 0; a < NL; a += 2) acc((a + 2) % NM, 0, 1, a, 32'hFFFF_FFFE, "R4");
        for (int a = 0; a < NL; a++) acc(a % NM, 1, 0, a, '0, "R10");

        // R4: write with bit 0 set holds the lock, upper bits ignored.
        acc(0, 0, 1, 3, 32'h0000_0000, "R4");
        acc(1, 0, 1, 3, 32'h7FFF_0001, "R4");
        acc(2, 1, 0, 3, '0, "R4");

        // R9: both strobes on a held lock act as a read; data ignored.
        acc(1, 1, 1, 2, 32'h0, "R9");
        acc(0, 1, 0, 2, '0, "R9");

        // R6 R7 R8: three readers of the same free lock at once.
        for (int start = 0; start < NM; start++) begin
            acc(start, 0, 1, 9, 32'h0, "R8");
            acc(start, 0, 1, 11, 32'h0, "R8");
            for (int m = 0; m < NM; m++) begin
                c_rd[m] = 1'b1; c_wr[m] = 1'b0; c_ad[m] = 9; c_wd[m] = '0;
            end
            contend(3'b111, "R7");
            // R6: mixed reads and writes of two locks.
            for (int m = 0; m < NM; m++) begin
                c_rd[m] = (m != start); c_wr[m] = (m == start);
                c_ad[m] = (m == 1) ? 11 : 9; c_wd[m] = 32'hABCD_0000;
            end
            contend(3'b111, "R6");
            contend(3'b101, "R8");
        end

        // R1: reset in mid-run clears the whole set again.
        do_reset();
        for (int a = 0; a < NL; a++) acc(a % NM, 1, 0, a, '0, "R1");

        summary();
        $finish;
    end

endmodule